// File: doc/BRIEF.md
# Start-up Readiness Sequencer

This block decides when a device with a factory-fixed function is ready for use after power is applied. A pulse from the analog power-on detector comes in as `por_i`. While that pulse is high, the block holds user logic in reset and latches a two-bit strap that chooses one of three start-up styles:

- **Immediate.** Ready as soon as power-on reset ends.
- **Delayed.** Ready after a nominal 50 ms hold.
- **Emulated.** Ready after replaying a serial configuration load. The block counts configuration clocks until it has seen as many as a real load would need. The configuration bits themselves are not stored, because the function cannot change.

Readiness is shown on an open-drain style done pin. It is modelled as an output enable, `done_oe_o`, together with a data value that is always low. When the enable is high the pin is pulled low. When the enable is low the pin is released to high impedance, so several devices can share one wired-AND line. The user-logic reset, `user_rst_o`, is released in the same cycle as the done pin.

The sequencer has four states:

- **PWRUP.** Entered whenever `por_i` is high.
- **HOLD.** The delay timer is running.
- **EMULATE.** Configuration clocks are being counted.
- **READY.** Done is released and user logic runs.

The transitions are:

- **boot_imm:** PWRUP to READY for strap 00 or 11.
- **boot_hold:** PWRUP to HOLD for strap 01.
- **boot_emu:** PWRUP to EMULATE for strap 10.
- **hold_expire:** HOLD to READY when the timer ends.
- **emu_complete:** EMULATE to READY when the clock count is reached.
- **emu_restart:** READY to EMULATE when the start control falls in emulation mode.
- **por_entry:** any state to PWRUP.

Top module: `startup_seq`

## Requirements
- R1: The strap `mode_strap_i` is captured on every clock edge where `por_i` is high, and it is held unchanged after `por_i` falls. The encodings are 00 immediate, 01 delayed, 10 emulated and 11 immediate. Strap changes after power-on reset have no effect.
- R2: While `por_i` is high, `user_rst_o` is 1 and `done_oe_o` is 1.
- R3: In immediate mode, `done_oe_o` and `user_rst_o` are 0 after the first clock edge at which `por_i` is sampled low.
- R4: In delayed mode, `done_oe_o` stays 1 through edge number HOLD_CYCLES after `por_i` falls, and is 0 from edge HOLD_CYCLES+1 onward. HOLD_CYCLES = (CLK_HZ/1000)*HOLD_MS.
- R5: In immediate and delayed modes, activity on `cfg_start_i` and `cfg_clk_i` does not change when `done_oe_o` is released.
- R6: In emulated mode, each rising edge of `cfg_clk_i` seen while `cfg_start_i` is high adds one to a count. Each level of `cfg_clk_i` must last at least 2 clock periods. `done_oe_o` falls to 0 within 5 clock edges after the CFG_BITS-th counted edge, and not before that edge.
- R7: Rising edges of `cfg_clk_i` while `cfg_start_i` is low are not counted. Driving `cfg_start_i` low during emulation clears the count.
- R8: In emulated mode, driving `cfg_start_i` low after release sets `done_oe_o` and `user_rst_o` back to 1 within 4 edges. A full new count of CFG_BITS edges is then needed to release them again.
- R9: `user_rst_o` equals `done_oe_o` in every cycle and every mode.
- R10: `done_val_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset pulse from the analog detector, active high |
| mode_strap_i | input | 2 | Start-up style strap |
| cfg_start_i | input | 1 | Configuration start control; high runs, low restarts |
| cfg_clk_i | input | 1 | Configuration clock, sampled into the system domain |
| user_rst_o | output | 1 | Reset to user logic, active high |
| done_oe_o | output | 1 | Done pin drive enable; 1 pulls the pin low |
| done_val_o | output | 1 | Done pin data, always low |

## Verification
The hardest situation to reach is a restart of emulation: one that happens partway through a count, and another that happens after release. This is where a stale count could let the done pin go early. The stimulus reaches it in steps. It first loads ten configuration clocks and then drops the start control. It then shows that fifteen fresh clocks still leave the pin driven. After the release, it drops the start control again and confirms that a full new count is needed. A second sequence changes the strap after power-on reset, then proves that emulation mode is still in force by completing a count.

// File: rtl/startup_pkg.sv
package startup_pkg;

    typedef enum logic [1:0] {
        MODE_IMM     = 2'b00,
        MODE_DELAY   = 2'b01,
        MODE_EMU     = 2'b10,
        MODE_IMM_ALT = 2'b11
    } boot_mode_e;

    typedef enum logic [1:0] {
        ST_PWRUP   = 2'b00,
        ST_HOLD    = 2'b01,
        ST_EMULATE = 2'b10,
        ST_READY   = 2'b11
    } seq_state_e;

endpackage

// File: rtl/startup_sync.sv
module startup_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (clr) stage_q <= 1'b0;
                else     stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] pipe_q;
            always_ff @(posedge clk) begin
                if (clr) pipe_q <= '0;
                else     pipe_q <= {pipe_q[STAGES-2:0], d};
            end
            assign q = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/startup_hold_timer.sv
module startup_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 100
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int unsigned HW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr || !en) cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = en && (cnt_q == HW'(HOLD_CYCLES - 1));

    // R4
    hold_count_step_chk: assert property (@(posedge clk) disable iff (clr)
        ($past(en) && en && !$past(expired)) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/startup_cfg_counter.sv
module startup_cfg_counter #(
    parameter int unsigned CFG_BITS = 1024
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic start_s,
    input  logic cclk_s,
    output logic full
);
    localparam int unsigned CW = $clog2(CFG_BITS + 1);

    logic          prev_q;
    logic          rise;
    logic [CW-1:0] cnt_q;

    assign rise = cclk_s && !prev_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= cclk_s;
            if (!en || !start_s)
                cnt_q <= '0;
            else if (rise && !full)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == CW'(CFG_BITS));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (clr)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));

    // R7
    gated_edge_chk: assert property (@(posedge clk) disable iff (clr)
        (!start_s) |=> (cnt_q == '0));
endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned HOLD_MS     = 50,
    parameter int unsigned CFG_BITS    = 1_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic [1:0] mode_strap_i,
    input  logic       cfg_start_i,
    input  logic       cfg_clk_i,
    output logic       user_rst_o,
    output logic       done_oe_o,
    output logic       done_val_o
);
    localparam int unsigned HOLD_RAW    = (CLK_HZ / 1000) * HOLD_MS;
    localparam int unsigned HOLD_CYCLES = (HOLD_RAW == 0) ? 1 : HOLD_RAW;

    boot_mode_e mode_q;
    seq_state_e state_q, state_d;
    logic       start_s, cclk_s;
    logic       hold_done, cnt_full;
    logic       hold_run, emu_run, released;

    // strap capture: transparent during power-on reset, frozen afterwards
    always_ff @(posedge clk) begin
        if (por_i) mode_q <= boot_mode_e'(mode_strap_i);
    end

    startup_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
        .clk(clk), .clr(por_i), .d(cfg_start_i), .q(start_s)
    );

    startup_sync #(.STAGES(SYNC_STAGES)) u_sync_cclk (
        .clk(clk), .clr(por_i), .d(cfg_clk_i), .q(cclk_s)
    );

    startup_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .clr(por_i), .en(hold_run), .expired(hold_done)
    );

    startup_cfg_counter #(.CFG_BITS(CFG_BITS)) u_cfgcnt (
        .clk(clk), .clr(por_i), .en(emu_run), .start_s(start_s),
        .cclk_s(cclk_s), .full(cnt_full)
    );

    // state register
    always_ff @(posedge clk) begin
        if (por_i) state_q <= ST_PWRUP;
        else       state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP: begin
                unique case (mode_q)
                    MODE_IMM, MODE_IMM_ALT: state_d = ST_READY;
                    MODE_DELAY:             state_d = ST_HOLD;
                    MODE_EMU:               state_d = ST_EMULATE;
                endcase
            end
            ST_HOLD:    if (hold_done) state_d = ST_READY;
            ST_EMULATE: if (cnt_full)  state_d = ST_READY;
            ST_READY:   if (mode_q == MODE_EMU && !start_s) state_d = ST_EMULATE;
        endcase
    end

    // outputs
    always_comb begin
        hold_run = (state_q == ST_HOLD);
        emu_run  = (state_q == ST_EMULATE);
        released = (state_q == ST_READY);
    end

    assign user_rst_o = !released;
    assign done_oe_o  = !released;
    assign done_val_o = 1'b0;

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        !$past(por_i) |-> $stable(mode_q));

    // R3
    imm_release_chk: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_PWRUP && (mode_q == MODE_IMM || mode_q == MODE_IMM_ALT))
        |=> !done_oe_o);

    // R4
    hold_exit_chk: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_READY && $past(state_q) == ST_HOLD) |-> $past(hold_done));

    // R6
    emu_exit_chk: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_READY && $past(state_q) == ST_EMULATE) |-> $past(cnt_full));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_READY && mode_q == MODE_EMU && !start_s) |=> (state_q == ST_EMULATE));
endmodule

// File: tb/startup_seq_test.sv
module startup_seq_test;
    localparam int unsigned T_CLK_HZ = 2000;
    localparam int unsigned T_HOLD   = 50;
    localparam int unsigned T_HCYC   = (T_CLK_HZ / 1000) * T_HOLD;
    localparam int unsigned T_BITS   = 16;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic [1:0] mode_strap_i = 2'b00;
    logic       cfg_start_i = 1'b0;
    logic       cfg_clk_i = 1'b0;
    logic       user_rst_o, done_oe_o, done_val_o;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    startup_seq #(.CLK_HZ(T_CLK_HZ), .HOLD_MS(T_HOLD), .CFG_BITS(T_BITS), .SYNC_STAGES(2)) uut (
        .clk(clk), .por_i(por_i), .mode_strap_i(mode_strap_i),
        .cfg_start_i(cfg_start_i), .cfg_clk_i(cfg_clk_i),
        .user_rst_o(user_rst_o), .done_oe_o(done_oe_o), .done_val_o(done_val_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // done enable plus the pairing with reset and the constant data value
    task automatic expect_oe(input logic exp, input string tag);
        check(done_oe_o === exp, tag, int'(done_oe_o), int'(exp));
        check(user_rst_o === done_oe_o, "R9 reset tracks done", int'(user_rst_o), int'(done_oe_o));
        check(done_val_o === 1'b0, "R10 done data low", int'(done_val_o), 0);
    endtask

    task automatic do_por(input logic [1:0] mode);
        por_i = 1'b1;
        mode_strap_i = mode;
        repeat (3) @(negedge clk);
        expect_oe(1'b1, "R2 held during power-on reset");
        por_i = 1'b0;
    endtask

    task automatic cfg_pulse();
        cfg_clk_i = 1'b1;
        repeat (3) @(negedge clk);
        cfg_clk_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        expect_oe(1'b1, "R2 reset state");
    endtask

    task automatic t_immediate();
        cfg_start_i = 1'b0;
        do_por(2'b00);
        @(negedge clk);
        expect_oe(1'b0, "R3 immediate release");
    endtask

    task automatic t_delay();
        do_por(2'b01);
        for (int k = 1; k <= T_HCYC + 1; k++) begin
            @(negedge clk);
            if (k == T_HCYC)     expect_oe(1'b1, "R4 still held at last hold cycle (R5 inputs toggling)");
            if (k == T_HCYC + 1) expect_oe(1'b0, "R4 released after hold (R5)");
            cfg_clk_i   = k[1];
            cfg_start_i = k[2];
        end
        cfg_clk_i = 1'b0;
        cfg_start_i = 1'b0;
    endtask

    task automatic t_emu();
        cfg_start_i = 1'b0;
        do_por(2'b10);
        repeat (5) cfg_pulse();
        expect_oe(1'b1, "R7 edges with start low not counted");
        cfg_start_i = 1'b1;
        repeat (4) @(negedge clk);
        repeat (T_BITS - 1) cfg_pulse();
        expect_oe(1'b1, "R6 held one edge short");
        cfg_pulse();
        expect_oe(1'b0, "R6 released at full count");
    endtask

    task automatic t_restart();
        cfg_start_i = 1'b0;
        repeat (4) @(negedge clk);
        expect_oe(1'b1, "R8 restart after release");
        cfg_start_i = 1'b1;
        repeat (4) @(negedge clk);
        repeat (10) cfg_pulse();
        cfg_start_i = 1'b0;
        repeat (4) @(negedge clk);
        cfg_start_i = 1'b1;
        repeat (4) @(negedge clk);
        repeat (T_BITS - 1) cfg_pulse();
        expect_oe(1'b1, "R7 mid-count restart clears count");
        cfg_pulse();
        expect_oe(1'b0, "R8 released after full new count");
    endtask

    task automatic t_mode_hold();
        cfg_start_i = 1'b0;
        do_por(2'b10);
        mode_strap_i = 2'b00;
        repeat (30) @(negedge clk);
        expect_oe(1'b1, "R1 strap change after reset ignored");
        cfg_start_i = 1'b1;
        repeat (4) @(negedge clk);
        repeat (T_BITS) cfg_pulse();
        expect_oe(1'b0, "R1 latched emulation mode completes");
    endtask

    task automatic t_mode_alt();
        cfg_start_i = 1'b1;
        cfg_clk_i = 1'b1;
        do_por(2'b11);
        @(negedge clk);
        expect_oe(1'b0, "R1 strap 11 behaves as immediate (R3, R5)");
        cfg_start_i = 1'b0;
        cfg_clk_i = 1'b0;
        repeat (6) @(negedge clk);
        expect_oe(1'b0, "R5 start low ignored in immediate mode");
    endtask

    initial begin
        t_reset();
        t_immediate();
        t_delay();
        t_emu();
        t_restart();
        t_mode_hold();
        t_mode_alt();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule